// File: doc/BRIEF.md
# Reference Clock Activity and Frequency Qualifier

This block decides whether one incoming reference clock can be trusted. It runs on a local 49.152 MHz master clock. It brings the reference into that domain through a two-flop synchronizer and detects its rising edges there. Two independent checks then run on those edges.

The first check looks for activity. A timer of programmable length runs continuously, and it declares a failure at the end of any window in which no edge arrived, so a dead input is caught quickly. The second check tests frequency accuracy within a ±1% band. With an 8 kHz nominal input it measures every input period in master cycles. With a 25 MHz nominal input it divides the input by 8 and counts the divided edges over a fixed master-clock window. A configuration input picks which of the two nominal rates applies.

The block drives one qualified flag. Both checks must agree before the input counts as usable. The result of each check is also available on its own output.

Top module: `refmon_top`

## Requirements
- R1: While reset is high and on the first edge after it, `valid`, `act_fail` and `freq_fail` are all 0. `valid` stays 0 until frequency evaluations have passed.
- R2: With `fast_sel`=0 (8 kHz nominal), each interval between two consecutive rising input edges is measured in master cycles. It passes only when it lies in 6083..6205 inclusive, and `freq_fail` then shows that verdict.
- R3: With `fast_sel`=0, an interval that reaches 6206 master cycles without a closing edge fails at that point, without waiting for the edge. The edge that ends it only restarts the measurement, and the interval after it is judged normally.
- R4: With `fast_sel`=1 (25 MHz nominal), the input is divided by 8. Rising edges of the divided signal are counted over back-to-back windows of 4096 master cycles, starting at reset release. A window passes only when its count lies in 258..263 inclusive.
- R5: An activity window lasts `act_win`+1 master cycles. At its end, `act_fail` is set if no rising edge of the monitored signal arrived during the window, and cleared otherwise. It changes at no other time.
- R6: `valid` drops to 0 at the end of any failing frequency evaluation. It also drops at the end of any failing activity window, without waiting for the next frequency evaluation.
- R7: `valid` rises only at the end of the second consecutive passing frequency evaluation with activity good. It changes only at the end of a frequency evaluation or an activity window.
- R8: Monitoring is continuous. After a failure, the input is qualified again by two fresh consecutive passes with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 49.152 MHz |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock under test |
| fast_sel | input | 1 | 0 = 8 kHz nominal, 1 = 25 MHz nominal |
| act_win | input | 16 | Activity window length minus one, in master cycles |
| valid | output | 1 | Reference is qualified |
| act_fail | output | 1 | Last activity window saw no edge |
| freq_fail | output | 1 | Last frequency evaluation was out of band |

## Verification
The bench drives 8 kHz periods at both limits of the accepted range and one cycle outside each. A comparator with an off-by-one bound, or one that measures from the wrong edge, would flip exactly one of those verdicts. A long period is checked mid-interval, so a design that waits for the closing edge before failing would still show the old verdict. In 25 MHz mode the bench stops the input partway through a window. It then expects `valid` to drop while `freq_fail` still shows the previous window, which separates the fast activity path from the slower count path. Recovery checks that one pass alone never re-qualifies the input, which catches a design that forgets its pass streak.

// File: rtl/refmon_pkg.sv
`timescale 1ns/1ps
package refmon_pkg;
  function automatic longint div_up(input longint num, input longint den);
    return (num + den - 1) / den;
  endfunction

  function automatic longint div_down(input longint num, input longint den);
    return num / den;
  endfunction
endpackage

// File: rtl/refmon_prescale.sv
`timescale 1ns/1ps
module refmon_prescale #(
  parameter int DIV = 8
) (
  input  logic ref_clk,
  input  logic rst,
  output logic div_out
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge ref_clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign div_out = cnt[CW-1];
endmodule

// File: rtl/refmon_sync_edge.sv
`timescale 1ns/1ps
module refmon_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= sr[STAGES-1];
  end

  assign rise = sr[STAGES-1] & ~last;
endmodule

// File: rtl/refmon_freq_check.sv
`timescale 1ns/1ps
module refmon_freq_check #(
  parameter int SLOW_LO  = 6083,
  parameter int SLOW_HI  = 6205,
  parameter int FAST_LO  = 258,
  parameter int FAST_HI  = 263,
  parameter int FAST_WIN = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_mode,
  input  logic rise,
  output logic eval_stb,
  output logic eval_ok
);
  localparam int PCNT_W = $clog2(SLOW_HI + 2);
  localparam int WCNT_W = $clog2(FAST_WIN);
  localparam int ECNT_W = $clog2(FAST_WIN + 1);

  // period measurement, slow nominal rate
  logic [PCNT_W-1:0] pcnt;
  logic              armed;
  logic              timeout, slow_stb, slow_ok;

  assign timeout  = armed && (pcnt == PCNT_W'(SLOW_HI + 1));
  assign slow_stb = armed && (rise || timeout);
  assign slow_ok  = rise && armed && (pcnt >= PCNT_W'(SLOW_LO)) && (pcnt <= PCNT_W'(SLOW_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      pcnt  <= '0;
    end else if (rise) begin
      armed <= 1'b1;
      pcnt  <= PCNT_W'(1);
    end else if (timeout) begin
      armed <= 1'b0;
    end else if (armed) begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // edge count over a fixed window, fast nominal rate
  logic [WCNT_W-1:0] wcnt;
  logic [ECNT_W-1:0] ecnt, ecnt_now;
  logic              win_end, fast_ok;

  assign win_end  = (wcnt == WCNT_W'(FAST_WIN - 1));
  assign ecnt_now = ecnt + ECNT_W'(rise);
  assign fast_ok  = (ecnt_now >= ECNT_W'(FAST_LO)) && (ecnt_now <= ECNT_W'(FAST_HI));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (win_end) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
      ecnt <= ecnt_now;
    end
  end

  assign eval_stb = fast_mode ? win_end : slow_stb;
  assign eval_ok  = fast_mode ? fast_ok : slow_ok;
endmodule

// File: rtl/refmon_activity.sv
`timescale 1ns/1ps
module refmon_activity #(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic [ACT_W-1:0] win_len,
  output logic             win_end,
  output logic             win_ok
);
  logic [ACT_W-1:0] tcnt;
  logic             seen;

  assign win_end = (tcnt >= win_len);
  assign win_ok  = seen | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      seen <= 1'b0;
    end else if (win_end) begin
      tcnt <= '0;
      seen <= 1'b0;
    end else begin
      tcnt <= tcnt + 1'b1;
      seen <= seen | rise;
    end
  end
endmodule

// File: rtl/refmon_top.sv
`timescale 1ns/1ps
module refmon_top #(
  parameter int MCLK_KHZ  = 49152,
  parameter int SLOW_KHZ  = 8,
  parameter int FAST_KHZ  = 25000,
  parameter int PRESCALE  = 8,
  parameter int FAST_WIN  = 4096,
  parameter int TOL_PCT   = 1,
  parameter int SYNC_STG  = 2,
  parameter int PASS_NEED = 2,
  parameter int ACT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fast_sel,
  input  logic [ACT_W-1:0] act_win,
  output logic             valid,
  output logic             act_fail,
  output logic             freq_fail
);
  import refmon_pkg::*;

  localparam longint SLOW_NOM = longint'(MCLK_KHZ) / SLOW_KHZ;
  localparam int     SLOW_LO  = int'(div_up(SLOW_NOM * (100 - TOL_PCT), 100));
  localparam int     SLOW_HI  = int'(div_down(SLOW_NOM * (100 + TOL_PCT), 100));
  localparam longint FAST_NUM = longint'(FAST_WIN) * FAST_KHZ;
  localparam longint FAST_DEN = longint'(100) * MCLK_KHZ * PRESCALE;
  localparam int     FAST_LO  = int'(div_up(FAST_NUM * (100 - TOL_PCT), FAST_DEN));
  localparam int     FAST_HI  = int'(div_down(FAST_NUM * (100 + TOL_PCT), FAST_DEN));
  localparam int     SW       = $clog2(PASS_NEED + 1);

  logic div_clk, mon_sig, rise;
  logic freq_stb, freq_ok, act_end, act_ok, act_bad;
  logic [SW-1:0] streak;

  refmon_prescale #(.DIV(PRESCALE)) u_div (
    .ref_clk (ref_in),
    .rst     (rst),
    .div_out (div_clk)
  );

  assign mon_sig = fast_sel ? div_clk : ref_in;

  refmon_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (mon_sig),
    .rise (rise)
  );

  refmon_freq_check #(
    .SLOW_LO  (SLOW_LO),
    .SLOW_HI  (SLOW_HI),
    .FAST_LO  (FAST_LO),
    .FAST_HI  (FAST_HI),
    .FAST_WIN (FAST_WIN)
  ) u_freq (
    .clk       (clk),
    .rst       (rst),
    .fast_mode (fast_sel),
    .rise      (rise),
    .eval_stb  (freq_stb),
    .eval_ok   (freq_ok)
  );

  refmon_activity #(.ACT_W(ACT_W)) u_act (
    .clk     (clk),
    .rst     (rst),
    .rise    (rise),
    .win_len (act_win),
    .win_end (act_end),
    .win_ok  (act_ok)
  );

  assign act_bad = act_end ? !act_ok : act_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      act_fail  <= 1'b0;
      freq_fail <= 1'b0;
      streak    <= '0;
    end else begin
      if (act_end)  act_fail  <= !act_ok;
      if (freq_stb) freq_fail <= !freq_ok;
      if (act_end && !act_ok) begin
        streak <= '0;
        valid  <= 1'b0;
      end else if (freq_stb) begin
        if (freq_ok && !act_bad) begin
          if (streak < SW'(PASS_NEED)) streak <= streak + 1'b1;
          if (streak >= SW'(PASS_NEED - 1)) valid <= 1'b1;
        end else begin
          streak <= '0;
          valid  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/refmon_checker.sv
`timescale 1ns/1ps
module refmon_checker (
  input logic clk,
  input logic rst,
  input logic valid,
  input logic act_fail,
  input logic freq_fail,
  input logic freq_stb,
  input logic act_end
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!valid && !act_fail && !freq_fail)); // R1

  AST_ACT_FAIL_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    act_fail |-> !valid); // R6

  AST_FREQ_FAIL_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    freq_fail |-> !valid); // R6

  AST_VALID_ONLY_AT_EVENTS: assert property (@(posedge clk) disable iff (rst)
    (!freq_stb && !act_end) |=> $stable(valid)); // R7

  AST_VALID_RISE_ON_EVAL: assert property (@(posedge clk) disable iff (rst)
    (!freq_stb) |=> !$rose(valid)); // R7

  AST_ACT_FLAG_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
    (!act_end) |=> $stable(act_fail)); // R5

  AST_FREQ_FLAG_AT_EVAL: assert property (@(posedge clk) disable iff (rst)
    (!freq_stb) |=> $stable(freq_fail)); // R2
endmodule

bind refmon_top refmon_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (valid),
  .act_fail  (act_fail),
  .freq_fail (freq_fail),
  .freq_stb  (freq_stb),
  .act_end   (act_end)
);

// File: tb/refmon_top_test.sv
`timescale 1ns/1ps
module refmon_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_sel = 1'b0;
  logic        ref_slow = 1'b0;
  logic        ref_fast = 1'b0;
  logic        fast_en = 1'b0;
  real         fast_half = 9.8304;
  logic [15:0] act_win = 16'd8191;
  logic        valid, act_fail, freq_fail;
  logic        ref_in;

  int n_chk = 0, n_fail = 0;
  int m_streak = 0;
  logic m_valid = 1'b0, m_ff = 1'b0;
  int prev_p = 0;
  bit prev_done = 0;

  always #5 clk = ~clk;
  assign ref_in = fast_sel ? ref_fast : ref_slow;

  refmon_top uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fast_sel(fast_sel),
    .act_win(act_win), .valid(valid), .act_fail(act_fail), .freq_fail(freq_fail)
  );

  initial begin
    forever begin
      if (fast_en) begin
        #(fast_half) ref_fast = ~ref_fast;
      end else begin
        ref_fast = 1'b0;
        #1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic bit slow_pass(input int p);
    int lo = (6144 * 99 + 99) / 100;
    int hi = (6144 * 101) / 100;
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic bit fast_pass(input real r);
    real c = 4096.0 * 25000.0 * r / (49152.0 * 8.0);
    return (c >= 258.0) && (c <= 263.0);
  endfunction

  task automatic model_eval(input bit pass);
    if (pass) begin
      m_ff = 1'b0;
      if (m_streak < 2) m_streak++;
      m_valid = (m_streak >= 2);
    end else begin
      m_ff = 1'b1;
      m_streak = 0;
      m_valid = 1'b0;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_cyc(6);
    chk("R1", "valid in reset", valid, 1'b0);
    chk("R1", "act_fail in reset", act_fail, 1'b0);
    chk("R1", "freq_fail in reset", freq_fail, 1'b0);
    m_streak = 0; m_valid = 1'b0; m_ff = 1'b0;
    rst = 1'b0;
  endtask

  // one rising edge, then the rest of a period of p master cycles
  task automatic slow_cycle(input int p);
    bit early = 0;
    @(negedge clk);
    ref_slow = 1'b1;
    for (int i = 1; i < p; i++) begin
      @(negedge clk);
      if (i == 8) begin
        if (prev_p != 0) begin
          if (!prev_done) model_eval(slow_pass(prev_p));
          chk("R2", $sformatf("freq_fail after %0d", prev_p), freq_fail, m_ff);
          chk("R7", $sformatf("valid after %0d", prev_p), valid, m_valid);
          chk("R5", "act_fail while edges arrive", act_fail, 1'b0);
        end else begin
          chk("R1", "valid before any interval", valid, 1'b0);
        end
      end
      if (i == p / 2) ref_slow = 1'b0;
      if (i == 6216) begin
        model_eval(1'b0);
        early = 1;
        chk("R3", "freq_fail before closing edge", freq_fail, 1'b1);
        chk("R6", "valid dropped on timeout", valid, 1'b0);
      end
    end
    prev_p = p;
    prev_done = early;
  endtask

  task automatic fast_window(input real r, input int aw);
    fast_half = 19.6608 / r / 2.0;
    act_win = 16'(aw);
    wait_cyc(4096);
    model_eval(fast_pass(r));
    chk("R4", $sformatf("freq_fail ratio %f", r), freq_fail, m_ff);
    chk("R7", $sformatf("valid ratio %f", r), valid, m_valid);
    chk("R5", "act_fail fast running", act_fail, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // slow nominal rate
    fast_sel = 1'b0;
    act_win = 16'd8191;
    do_reset();
    slow_cycle(6144);
    slow_cycle(6144);
    slow_cycle(6082);
    slow_cycle(6083);
    slow_cycle(6205);
    slow_cycle(6206);
    slow_cycle(6144);
    for (int k = 0; k < 3; k++) slow_cycle(5950 + int'($urandom % 451));
    slow_cycle(7000);
    slow_cycle(6144);
    slow_cycle(6144);
    // input stops: both checks fail
    wait_cyc(2 * 8192 + 50);
    chk("R5", "act_fail after slow stop", act_fail, 1'b1);
    chk("R3", "freq_fail after slow stop", freq_fail, 1'b1);
    chk("R6", "valid after slow stop", valid, 1'b0);

    // fast nominal rate, all windows aligned to reset release
    fast_sel = 1'b1;
    fast_half = 9.8304;
    fast_en = 1'b1;
    act_win = 16'd400;
    wait_cyc(4);
    do_reset();
    wait_cyc(19);
    fast_window(1.0, 400);
    fast_window(1.0, 300);
    for (int k = 0; k < 3; k++) begin
      int  d    = int'($urandom % 4);
      bit  good = $urandom % 2;
      real r    = good ? 1.0 + (real'(d) - 1.5) / 500.0
                       : ((d % 2) ? 1.0 + (20.0 + real'(d) * 5.0) / 1000.0
                                  : 1.0 - (20.0 + real'(d) * 5.0) / 1000.0);
      fast_window(r, 100 + int'($urandom % 800));
    end
    // stop the input early in a window
    act_win = 16'd500;
    fast_en = 1'b0;
    wait_cyc(2 * 501 + 40);
    chk("R5", "act_fail after fast stop", act_fail, 1'b1);
    chk("R6", "valid drops before window end", valid, 1'b0);
    chk("R6", "freq_fail still previous verdict", freq_fail, m_ff);
    fast_half = 9.8304;
    fast_en = 1'b1;
    wait_cyc(4096 - (2 * 501 + 40));
    model_eval(1'b0);
    chk("R4", "freq_fail stopped window", freq_fail, 1'b1);
    chk("R5", "act_fail cleared after restart", act_fail, 1'b0);
    fast_window(1.0, 500);
    chk("R8", "one pass after recovery", valid, 1'b0);
    fast_window(1.0, 500);
    chk("R8", "requalified after two passes", valid, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule